// File: doc/BRIEF.md
# Master Serial Configuration Loader

This block is the receiving side of a serial configuration link. It makes its own configuration clock (`cclk_o`) by dividing the system clock. On every rising edge of that clock it samples one bit from an external serial memory (`ser_din`). While the load is running it also drives the memory's control lines. `init_n_o` is pulled Low for a few system clocks at the start of every load, which returns the memory's address counter to zero. `done_o` stays Low for the whole load and acts as the memory's active-Low chip enable.

The bit stream begins with a sync pattern: a run of at least `PRE_ONES` one bits, followed by the four-bit tag `0010`, sent left to right. Next comes a `LEN_W`-bit length field, sent MSB first. The length value is the total number of configuration clock pulses in the whole load, and it counts the sync and length bits too. Every bit after the length field is passed out on a one-cycle `bit_valid_o`/`bit_data_o` stream. When the last counted pulse has been issued, `done_o` goes High, which disables the memory. One configuration clock period later, `user_io_en_o` releases the user pins.

The block moves through seven states:
- **ST_IDLE** goes to ST_INIT when the mode pins read `000` and no error is held.
- **ST_INIT** holds `init_n_o` Low for `INIT_CYC` clocks, then goes to ST_HUNT.
- **ST_HUNT** goes to ST_LENGTH when the sync pattern is found. It returns to ST_IDLE with an error after 2^`LEN_W` pulses without a sync.
- **ST_LENGTH** goes to ST_LOAD after the last length bit, or to ST_IDLE with an error if the length leaves no room for payload.
- **ST_LOAD** goes to ST_RELEASE on the final counted pulse.
- **ST_RELEASE** goes to ST_DONE one clock period later.
- **ST_DONE** goes back to ST_IDLE when `reconfig_req` is asserted, which models an external agent pulling DONE Low.

Top module: `mserial_cfg_loader`

## Requirements
- R1: A load starts only from ST_IDLE, with `mode_sel` equal to `3'b000` and no error held. Any other mode value produces no INIT pulse and no clock pulse.
- R2: Every load begins with `init_n_o` Low for exactly `INIT_CYC` system clocks. No configuration clock pulse appears while `init_n_o` is Low.
- R3: `cclk_o` has a period of `2*DIV_HALF` system clocks and is High for `DIV_HALF` of them. Every pulse is full width, including the last pulse before an error stop.
- R4: The sync pattern is at least `PRE_ONES` consecutive ones followed by `0,0,1,0` in time order. Shorter runs of ones, or a broken tag, keep the loader hunting.
- R5: The `LEN_W`-bit length follows the tag, MSB first. The number of rising edges on `cclk_o` from the start of the load equals that length value.
- R6: Each bit sampled in ST_LOAD appears on `bit_data_o`, in order, with `bit_valid_o` High for one clock. That clock begins at the same edge at which `cclk_o` rises.
- R7: `done_o` is Low during the load and rises at the same edge as the final `cclk_o` rise. `user_io_en_o` rises exactly `2*DIV_HALF` clocks later.
- R8: After 2^`LEN_W` pulses with no sync found, `cfg_err_o` is set, the clock stops, and `done_o` stays Low.
- R9: A length value no larger than the number of pulses already used for sync and length sets `cfg_err_o` and stops the clock after the last length bit.
- R10: `cfg_err_o` holds, and blocks any new load, until `reconfig_req` is asserted.
- R11: `reconfig_req` in ST_DONE drops `done_o` and `user_io_en_o` at the next edge. A new load then restarts the memory from address 0. `reconfig_req` during a load has no effect on that load.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-Low asynchronous reset |
| mode_sel | input | 3 | Mode pins; `000` selects master serial loading |
| reconfig_req | input | 1 | External pull-down of DONE; requests a new load or clears an error |
| ser_din | input | 1 | Serial data from the configuration memory |
| cclk_o | output | 1 | Generated configuration clock |
| init_n_o | output | 1 | Active-Low memory reset at the start of a load |
| done_o | output | 1 | DONE line; Low enables the memory |
| user_io_en_o | output | 1 | High once the user pins are released |
| bit_valid_o | output | 1 | One-clock strobe for each payload bit |
| bit_data_o | output | 1 | Payload bit value |
| cfg_err_o | output | 1 | Sticky error: sync not found, or length too short |

## Verification
The timing of each result is fixed relative to the configuration clock:
- A payload strobe is up from the same edge at which `cclk_o` rises.
- `done_o` rises on the edge of the final counted pulse.
- `user_io_en_o` follows `done_o` by exactly `2*DIV_HALF` clocks.
- `init_n_o` is Low for `INIT_CYC` clocks.

The bench samples every output on the falling system clock edge. From those samples it records the cycle index of each rising edge, and it compares the differences between those indices to the figures above rather than waiting loosely for an outcome. Its behavioural memory advances on each `cclk_o` rise and resets while `init_n_o` is Low. The expected pulse counts and payload bits therefore follow directly from the frame the bench wrote.

// File: rtl/cfgld_pkg.sv
package cfgld_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_INIT,
        ST_HUNT,
        ST_LENGTH,
        ST_LOAD,
        ST_RELEASE,
        ST_DONE
    } cfg_state_t;

endpackage

// File: rtl/cfgld_cclk_gen.sv
// Configuration clock divider: DIV_HALF system clocks per half period.
// A pulse is shown on the pin only when gate is high at the rising point;
// once started, a pulse always completes its high half.
module cfgld_cclk_gen #(
    parameter int DIV_HALF = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic gate,
    output logic cclk,
    output logic rise
);

    localparam int CNT_W = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;
    localparam logic [CNT_W-1:0] HALF_LAST = CNT_W'(DIV_HALF - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             phase_q;
    logic             pin_q;

    assign rise = run && (cnt_q == HALF_LAST) && !phase_q;
    assign cclk = pin_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            phase_q <= 1'b0;
            pin_q   <= 1'b0;
        end else if (!run) begin
            cnt_q   <= '0;
            phase_q <= 1'b0;
            pin_q   <= 1'b0;
        end else if (cnt_q == HALF_LAST) begin
            cnt_q   <= '0;
            phase_q <= ~phase_q;
            pin_q   <= phase_q ? 1'b0 : gate;
        end else begin
            cnt_q   <= cnt_q + 1'b1;
        end
    end

    // R3: the pin is only ever high during the high half of the divider
    a_r3_pin_in_high_half: assert property (@(posedge clk) disable iff (!rst_n)
        pin_q |-> phase_q);

endmodule

// File: rtl/cfgld_sync_detect.sv
// Hunts for a run of PRE_ONES ones followed by the 4-bit tag (MSB first in time).
module cfgld_sync_detect #(
    parameter int         PRE_ONES = 8,
    parameter logic [3:0] PRE_TAG  = 4'b0010
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic sample,
    input  logic bit_in,
    output logic found
);

    localparam int ONES_W = $clog2(PRE_ONES + 1);
    localparam logic [ONES_W-1:0] ONES_FULL = ONES_W'(PRE_ONES);

    logic [ONES_W-1:0] ones_q;
    logic [1:0]        idx_q;
    logic              exp_bit;

    always_comb begin
        exp_bit = PRE_TAG[2'd3 - idx_q];
        found   = sample && (idx_q == 2'd3) && (bit_in == exp_bit);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ones_q <= '0;
            idx_q  <= '0;
        end else if (clear) begin
            ones_q <= '0;
            idx_q  <= '0;
        end else if (sample) begin
            if (idx_q == 2'd0) begin
                if (ones_q == ONES_FULL && bit_in == PRE_TAG[3]) begin
                    idx_q <= 2'd1;
                end else if (bit_in) begin
                    if (ones_q != ONES_FULL) ones_q <= ones_q + 1'b1;
                end else begin
                    ones_q <= '0;
                end
            end else if (bit_in == exp_bit) begin
                idx_q <= idx_q + 1'b1;
                if (idx_q == 2'd3) ones_q <= '0;
            end else begin
                idx_q  <= 2'd0;
                ones_q <= bit_in ? ONES_W'(1) : '0;
            end
        end
    end

    // R4: the tag phase is only entered from a complete run of ones
    a_r4_tag_after_run: assert property (@(posedge clk) disable iff (!rst_n)
        (idx_q == 2'd1 && $past(idx_q) == 2'd0) |-> ($past(ones_q) == ONES_FULL));

endmodule

// File: rtl/cfgld_len_track.sv
// Length shift register and total pulse counter with their comparisons.
module cfgld_len_track #(
    parameter int LEN_W = 24
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic count_en,
    input  logic shift_en,
    input  logic bit_in,
    output logic len_last,
    output logic len_short,
    output logic pulses_hit,
    output logic cap_hit
);

    localparam int CW    = LEN_W + 1;
    localparam int IDX_W = (LEN_W > 1) ? $clog2(LEN_W) : 1;
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(LEN_W - 1);
    localparam logic [CW-1:0]    CAP_PRE  = {1'b0, {LEN_W{1'b1}}};
    localparam logic [CW-1:0]    CAP_MAX  = {1'b1, {LEN_W{1'b0}}};

    logic [LEN_W-1:0] len_q;
    logic [LEN_W-1:0] len_next;
    logic [CW-1:0]    pcnt_q;
    logic [CW-1:0]    pcnt_inc;
    logic [IDX_W-1:0] idx_q;

    always_comb begin
        len_next   = {len_q[LEN_W-2:0], bit_in};
        pcnt_inc   = pcnt_q + 1'b1;
        len_last   = shift_en && (idx_q == IDX_LAST);
        len_short  = ({1'b0, len_next} <= pcnt_inc);
        pulses_hit = count_en && (pcnt_inc == {1'b0, len_q});
        cap_hit    = count_en && (pcnt_q == CAP_PRE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            len_q  <= '0;
            pcnt_q <= '0;
            idx_q  <= '0;
        end else if (clear) begin
            len_q  <= '0;
            pcnt_q <= '0;
            idx_q  <= '0;
        end else begin
            if (count_en) pcnt_q <= pcnt_inc;
            if (shift_en) begin
                len_q <= len_next;
                idx_q <= idx_q + 1'b1;
            end
        end
    end

    // R8: never more than 2^LEN_W pulses in one load
    a_r8_pulse_bound: assert property (@(posedge clk) disable iff (!rst_n)
        pcnt_q <= CAP_MAX);

endmodule

// File: rtl/mserial_cfg_loader.sv
module mserial_cfg_loader
    import cfgld_pkg::*;
#(
    parameter int         DIV_HALF = 2,
    parameter int         INIT_CYC = 4,
    parameter int         PRE_ONES = 8,
    parameter int         LEN_W    = 24,
    parameter logic [3:0] PRE_TAG  = 4'b0010
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] mode_sel,
    input  logic       reconfig_req,
    input  logic       ser_din,
    output logic       cclk_o,
    output logic       init_n_o,
    output logic       done_o,
    output logic       user_io_en_o,
    output logic       bit_valid_o,
    output logic       bit_data_o,
    output logic       cfg_err_o
);

    localparam int ICW = (INIT_CYC > 1) ? $clog2(INIT_CYC + 1) : 1;
    localparam logic [ICW-1:0] INIT_LAST = ICW'(INIT_CYC - 1);
    localparam logic [2:0]     MODE_SERIAL_MASTER = 3'b000;

    cfg_state_t     state_q, state_d;
    logic           err_q, err_set;
    logic [ICW-1:0] init_cnt_q;
    logic           rise, cclk_pin, gen_active, run, gate;
    logic           sample_hunt, count_en, shift_en, clear_ctx;
    logic           sync_found, len_last, len_short, pulses_hit, cap_hit;
    logic           valid_q, data_q;

    always_comb begin
        gen_active  = state_q inside {ST_HUNT, ST_LENGTH, ST_LOAD, ST_RELEASE};
        gate        = state_q inside {ST_HUNT, ST_LENGTH, ST_LOAD};
        run         = gen_active || cclk_pin;
        sample_hunt = rise && (state_q == ST_HUNT);
        shift_en    = rise && (state_q == ST_LENGTH);
        count_en    = rise && gate;
        clear_ctx   = (state_q == ST_INIT);
    end

    cfgld_cclk_gen #(.DIV_HALF(DIV_HALF)) u_cclk (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .gate  (gate),
        .cclk  (cclk_pin),
        .rise  (rise)
    );

    cfgld_sync_detect #(.PRE_ONES(PRE_ONES), .PRE_TAG(PRE_TAG)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (clear_ctx),
        .sample (sample_hunt),
        .bit_in (ser_din),
        .found  (sync_found)
    );

    cfgld_len_track #(.LEN_W(LEN_W)) u_len (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (clear_ctx),
        .count_en   (count_en),
        .shift_en   (shift_en),
        .bit_in     (ser_din),
        .len_last   (len_last),
        .len_short  (len_short),
        .pulses_hit (pulses_hit),
        .cap_hit    (cap_hit)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        err_set = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (mode_sel == MODE_SERIAL_MASTER && !err_q) state_d = ST_INIT;
            end
            ST_INIT: begin
                if (init_cnt_q == INIT_LAST) state_d = ST_HUNT;
            end
            ST_HUNT: begin
                if (sync_found) begin
                    state_d = ST_LENGTH;
                end else if (cap_hit) begin
                    state_d = ST_IDLE;
                    err_set = 1'b1;
                end
            end
            ST_LENGTH: begin
                if (len_last) begin
                    if (len_short) begin
                        state_d = ST_IDLE;
                        err_set = 1'b1;
                    end else begin
                        state_d = ST_LOAD;
                    end
                end
            end
            ST_LOAD: begin
                if (pulses_hit) state_d = ST_RELEASE;
            end
            ST_RELEASE: begin
                if (rise) state_d = ST_DONE;
            end
            ST_DONE: begin
                if (reconfig_req) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register and sequencing counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            err_q      <= 1'b0;
            init_cnt_q <= '0;
            valid_q    <= 1'b0;
            data_q     <= 1'b0;
        end else begin
            state_q    <= state_d;
            if (err_set)           err_q <= 1'b1;
            else if (reconfig_req) err_q <= 1'b0;
            init_cnt_q <= (state_q == ST_INIT) ? init_cnt_q + 1'b1 : '0;
            valid_q    <= rise && (state_q == ST_LOAD);
            if (rise && state_q == ST_LOAD) data_q <= ser_din;
        end
    end

    // Output decode
    always_comb begin
        init_n_o     = (state_q != ST_INIT);
        done_o       = state_q inside {ST_RELEASE, ST_DONE};
        user_io_en_o = (state_q == ST_DONE);
        cfg_err_o    = err_q;
        cclk_o       = cclk_pin;
        bit_valid_o  = valid_q;
        bit_data_o   = data_q;
    end

    // R1: INIT only begins when the mode pins select serial master loading
    a_r1_mode_gate: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(init_n_o) |-> ($past(mode_sel) == MODE_SERIAL_MASTER));

    // R2: no clock pulse and no DONE while the memory is held in reset
    a_r2_init_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !init_n_o |-> (!cclk_o && !done_o));

    // R6: a payload strobe coincides with a high configuration clock
    a_r6_valid_on_cclk: assert property (@(posedge clk) disable iff (!rst_n)
        bit_valid_o |-> cclk_o);

    // R7: user pins never released without DONE, and DONE leads the release
    a_r7_io_needs_done: assert property (@(posedge clk) disable iff (!rst_n)
        user_io_en_o |-> done_o);
    a_r7_done_leads_io: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(user_io_en_o) |-> $past(done_o));

    // R8: an error load never raises DONE
    a_r8_err_no_done: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err_o |-> !done_o);

    // R10: the error holds until a reconfiguration request
    a_r10_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_err_o && !reconfig_req) |=> cfg_err_o);

endmodule

// File: tb/tb_mserial_cfg_loader.sv
module tb_mserial_cfg_loader;

    localparam int DIV   = 2;
    localparam int INITC = 4;
    localparam int ONESN = 8;
    localparam int LW    = 12;
    localparam int MEMD  = 1024;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] mode_sel = 3'b011;
    logic       reconfig_req = 1'b0;
    logic       ser_din;
    logic       cclk_o, init_n_o, done_o, user_io_en_o, bit_valid_o, bit_data_o, cfg_err_o;

    always #5 clk = ~clk;

    mserial_cfg_loader #(
        .DIV_HALF(DIV), .INIT_CYC(INITC), .PRE_ONES(ONESN), .LEN_W(LW), .PRE_TAG(4'b0010)
    ) dut (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .reconfig_req(reconfig_req),
        .ser_din(ser_din), .cclk_o(cclk_o), .init_n_o(init_n_o), .done_o(done_o),
        .user_io_en_o(user_io_en_o), .bit_valid_o(bit_valid_o), .bit_data_o(bit_data_o),
        .cfg_err_o(cfg_err_o)
    );

    // Behavioural serial memory
    logic mem [0:MEMD-1];
    int   addr = 0;
    always @(posedge cclk_o or negedge init_n_o) begin
        if (!init_n_o) addr <= 0;
        else           addr <= addr + 1;
    end
    assign ser_din = (addr < MEMD) ? mem[addr] : 1'b1;

    // Frame bookkeeping
    int exp_len, exp_hdr, exp_pay, pay_base;

    // Monitor state, sampled on falling edges
    int cyc = 0;
    int pulses, init_low, last_rise, t_done, t_io, got, mism, hi_run;
    bit bad_clk;
    logic prev_cclk = 1'b0, prev_done = 1'b0, prev_io = 1'b0;

    int checks = 0;
    int errors = 0;

    task automatic clr_mon();
        pulses = 0; init_low = 0; last_rise = -1; t_done = -1; t_io = -1;
        got = 0; mism = 0; hi_run = 0; bad_clk = 1'b0;
    endtask

    always @(negedge clk) begin
        cyc++;
        if (!init_n_o) init_low++;
        if (cclk_o) hi_run++;
        if (cclk_o && !prev_cclk) begin
            pulses++;
            if (last_rise >= 0 && (cyc - last_rise) != 2 * DIV) bad_clk = 1'b1;
            last_rise = cyc;
        end
        if (!cclk_o && prev_cclk) begin
            if (hi_run != DIV) bad_clk = 1'b1;
            hi_run = 0;
        end
        if (done_o && !prev_done) t_done = cyc;
        if (user_io_en_o && !prev_io) t_io = cyc;
        if (bit_valid_o) begin
            if ((pay_base + got) >= MEMD || bit_data_o !== mem[pay_base + got]) mism++;
            got++;
        end
        prev_cclk = cclk_o;
        prev_done = done_o;
        prev_io   = user_io_en_o;
    end

    task automatic check_eq(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Watchdog
    always @(posedge clk) begin
        if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog actual %0d expected %0d", cyc, 150000);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // Frame builder: optional junk, ones run, tag, length, random payload
    task automatic build_frame(bit junk, int ones, int plen);
        int p;
        int lv;
        p = 0;
        for (int i = 0; i < MEMD; i++) mem[i] = 1'b1;
        if (junk) begin
            for (int i = 0; i < 7; i++) begin mem[p] = 1'b1; p++; end
            mem[p] = 1'b0; p++; mem[p] = 1'b0; p++; mem[p] = 1'b1; p++; mem[p] = 1'b0; p++;
            for (int i = 0; i < 8; i++) begin mem[p] = 1'b1; p++; end
            mem[p] = 1'b0; p++; mem[p] = 1'b1; p++;
        end
        for (int i = 0; i < ones; i++) begin mem[p] = 1'b1; p++; end
        mem[p] = 1'b0; p++; mem[p] = 1'b0; p++; mem[p] = 1'b1; p++; mem[p] = 1'b0; p++;
        exp_hdr = p + LW;
        lv      = exp_hdr + plen;
        for (int b = LW - 1; b >= 0; b--) begin mem[p] = lv[b]; p++; end
        pay_base = p;
        for (int i = 0; i < plen; i++) begin mem[p] = 1'($urandom % 2); p++; end
        exp_len = lv;
        exp_pay = plen;
    endtask

    task automatic pulse_reconfig();
        @(posedge clk); #1 reconfig_req = 1'b1;
        @(posedge clk); #1 reconfig_req = 1'b0;
    endtask

    task automatic wait_end(int lim);
        int n;
        n = 0;
        @(negedge clk);
        while (!user_io_en_o && !cfg_err_o && n < lim) begin
            @(negedge clk);
            n++;
        end
        check_eq("load finished in time", (n < lim) ? 1 : 0, 1);
        repeat (20) @(negedge clk);
    endtask

    task automatic check_good();
        check_eq("R2 init low cycles", init_low, INITC);
        check_eq("R5 cclk pulse count", pulses, exp_len);
        check_eq("R6 payload bit count", got, exp_pay);
        check_eq("R4 R6 payload mismatches", mism, 0);
        check_eq("R3 cclk period and duty", int'(bad_clk), 0);
        check_eq("R7 done with last pulse", t_done, last_rise);
        check_eq("R7 io release delay", t_io - t_done, 2 * DIV);
        check_eq("R7 io released", int'(user_io_en_o), 1);
        check_eq("R8 R9 no error", int'(cfg_err_o), 0);
    endtask

    // Load started from DONE via reconfig, with an R11 check of the handover edge
    task automatic reload(bit mid_pulse);
        @(posedge clk); #1 clr_mon();
        reconfig_req = 1'b1;
        @(posedge clk); #1 reconfig_req = 1'b0;
        check_eq("R11 done drops after reconfig", int'(done_o), 0);
        check_eq("R11 io drops after reconfig", int'(user_io_en_o), 0);
        if (mid_pulse) begin
            repeat (300) @(posedge clk);
            #1 reconfig_req = 1'b1;
            @(posedge clk); #1 reconfig_req = 1'b0;
        end
        wait_end(20000);
    endtask

    initial begin
        void'($urandom(32'd7331));
        for (int i = 0; i < MEMD; i++) mem[i] = 1'b1;
        pay_base = 0;
        clr_mon();
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // Reset state and R1 with a non-serial mode
        repeat (80) @(negedge clk);
        check_eq("R1 reset cclk low", int'(cclk_o), 0);
        check_eq("R1 reset init high", int'(init_n_o), 1);
        check_eq("R7 reset done low", int'(done_o), 0);
        check_eq("R7 reset io low", int'(user_io_en_o), 0);
        check_eq("R6 reset valid low", int'(bit_valid_o), 0);
        check_eq("R10 reset no error", int'(cfg_err_o), 0);
        check_eq("R1 no init in mode 011", init_low, 0);
        check_eq("R1 no pulses in mode 011", pulses, 0);

        // First directed load: minimal ones run
        build_frame(1'b0, ONESN, 20);
        @(posedge clk); #1 clr_mon(); mode_sel = 3'b000;
        wait_end(20000);
        check_good();

        // R4: junk with short runs and broken tag before the real sync; R11 restart
        build_frame(1'b1, 10, 37);
        reload(1'b0);
        check_good();

        // Random loads; one with a reconfig pulse in mid-load (R11 ignored)
        for (int k = 0; k < 4; k++) begin
            build_frame(1'($urandom % 2), ONESN + int'($urandom % 8), 1 + int'($urandom % 300));
            reload(k == 2);
            check_good();
        end

        // R9: length equal to header pulses
        build_frame(1'b0, ONESN, 0);
        reload(1'b0);
        check_eq("R9 short length error", int'(cfg_err_o), 1);
        check_eq("R9 pulses stop at header", pulses, exp_hdr);
        check_eq("R9 done stays low", int'(done_o), 0);
        check_eq("R3 error pulse full width", int'(bad_clk), 0);

        // R10: error blocks a restart even in serial mode
        @(posedge clk); #1 clr_mon();
        repeat (60) @(negedge clk);
        check_eq("R10 no init while error", init_low, 0);
        check_eq("R10 no pulses while error", pulses, 0);
        check_eq("R10 error held", int'(cfg_err_o), 1);

        // R10 clear by reconfig, then a good load
        build_frame(1'b0, 12, 55);
        @(posedge clk); #1 clr_mon();
        pulse_reconfig();
        wait_end(20000);
        check_good();

        // R8: no sync at all
        for (int i = 0; i < MEMD; i++) mem[i] = 1'b1;
        reload(1'b0);
        check_eq("R8 hunt limit error", int'(cfg_err_o), 1);
        check_eq("R8 hunt pulse count", pulses, 1 << LW);
        check_eq("R8 done stays low", int'(done_o), 0);
        check_eq("R8 no payload", got, 0);

        // R1: clear error with a non-serial mode selected, no load may start
        @(posedge clk); #1 mode_sel = 3'b100; clr_mon();
        pulse_reconfig();
        repeat (60) @(negedge clk);
        check_eq("R1 no init in mode 100", init_low, 0);
        check_eq("R10 error cleared", int'(cfg_err_o), 0);

        // Mode back to serial: load starts
        build_frame(1'b0, 9, 64);
        @(posedge clk); #1 clr_mon(); mode_sel = 3'b000;
        wait_end(20000);
        check_good();

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule